// File: doc/BRIEF.md
# Miss Status Holding Register Entry

One outstanding-miss slot for a non-blocking cache. When a miss is opened, the entry records which line is missing. It stores the address, the address-space identifier, the command to send downstream and the transfer size. It also stamps the cycle on which the miss was opened, which is used for latency accounting. Requests that hit the same pending line are parked behind it as targets in an ordered queue. A drain port then hands the targets back one at a time, head first, once the fill returns.

Two ordering rules go beyond a plain FIFO.

- **Invalidate promotion.** Suppose the miss has already been issued as a read and an invalidate arrives. The invalidate is then slotted in right after the run of reads at the front of the queue, ahead of the first non-read target.
- **Write upgrade.** A write target that arrives before the miss is issued turns the outgoing command into a write.

Target append is a valid/ready stream. A beat transfers when `app_valid` and `app_ready` are both high. `app_ready` drops while the queue is full and during any cycle in which allocation or deallocation is requested; a producer holds its beat until ready returns. Target drain is also a valid/ready stream. `head_valid` is high whenever a target is queued, and a beat leaves when `head_ready` is also high. A pop and an append may transfer in the same cycle: the pop takes effect first, and the append is then placed in the shortened queue. Allocation, deallocation and the issue mark are plain single-cycle strobes.

Top module: `mshr_entry`

## Requirements
- R1: After reset the entry is not in service, holds zero targets, `head_valid` is low, `app_ready` is high and the thread number reads all ones (-1 in two's complement).
- R2: An allocate strobe records address, address-space ID, command and size, and sets `miss_time` to the value of a free-running cycle counter. Two allocations N clock edges apart therefore differ by N in `miss_time`. The strobe is legal only while the target count is zero; raising it otherwise is a protocol violation.
- R3: An allocate with `alloc_has_tgt` high puts that target at the head of the queue (count becomes 1) and copies `alloc_tgt_thread` into `miss_thread`.
- R4: An accepted append normally lands at the tail of the queue, and the count rises by one.
- R5: Promotion applies when the entry is in service, the outgoing command is read (code 0) and the appended target is an invalidate (code 2). The invalidate is then inserted directly before the first target whose code is not read, or at the tail if every queued target is a read.
- R6: When the entry is not in service, accepting a write target (code 1), either by append or as the allocation's first target, sets the outgoing command to write. Once in service, a write target leaves the command unchanged.
- R7: When the queue holds DEPTH targets, `tgt_full` is high and `app_ready` is low. The count and the queue contents stay as they were.
- R8: A drain beat removes the head and lowers the count by one. With an empty queue `head_valid` is low and `head_ready` has no effect. When a pop and an append occur in the same cycle, the pop applies first.
- R9: A deallocate strobe clears the in-service flag. It is legal only while the target count is zero.
- R10: The `mark_issue` strobe sets the in-service flag from the next cycle. If deallocation is requested in the same cycle, the deallocation wins.
- R11: `tgt_count` always equals the number of queued targets, never exceeds DEPTH, and `head_valid` is high exactly when it is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Open a new miss this cycle |
| alloc_addr | input | ADDRW | Miss line address |
| alloc_asid | input | ASIDW | Address-space identifier |
| alloc_cmd | input | 2 | Initial outgoing command (0 read, 1 write, 2 invalidate) |
| alloc_size | input | SZW | Transfer size |
| alloc_has_tgt | input | 1 | A first target accompanies the allocation |
| alloc_tgt_cmd | input | 2 | First target command code |
| alloc_tgt_tag | input | TAGW | First target tag |
| alloc_tgt_thread | input | THW | Thread number of the first target |
| app_valid | input | 1 | Append stream valid |
| app_ready | output | 1 | Append stream ready |
| app_cmd | input | 2 | Appended target command code |
| app_tag | input | TAGW | Appended target tag |
| mark_issue | input | 1 | Miss has been issued downstream |
| dealloc_valid | input | 1 | Release the entry |
| head_valid | output | 1 | Drain stream valid |
| head_ready | input | 1 | Drain stream ready |
| head_cmd | output | 2 | Command code of the head target |
| head_tag | output | TAGW | Tag of the head target |
| miss_cmd | output | 2 | Current outgoing command |
| miss_addr | output | ADDRW | Recorded address |
| miss_asid | output | ASIDW | Recorded address-space identifier |
| miss_size | output | SZW | Recorded size |
| miss_time | output | TSW | Cycle stamp taken at allocation |
| miss_thread | output | THW | Thread number of the first target |
| in_service | output | 1 | Miss has been issued |
| tgt_count | output | $clog2(DEPTH+1) | Number of queued targets |
| tgt_full | output | 1 | Queue holds DEPTH targets |

## Verification
The bench builds the entry with DEPTH set to 4 and 4-bit tags, threads and sizes. With these values four appends fill the queue, so the refusal of a fifth target is reachable within a few cycles. The bench checks that refusal by draining the queue afterwards and confirming the order and contents. An invalidate that is promoted past two reads while a write is also queued also fits inside this small depth. That lets every insertion position be reached: middle, tail after all reads, and tail because the command was already upgraded. A directed case overlaps a pop with a promoted append, which exercises pop-before-insert ordering.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_INV = 2'd2
  } mcmd_e;
endpackage

// File: rtl/mshr_tick.sv
module mshr_tick #(
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TSW-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/mshr_tq.sv
module mshr_tq
  import mshr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAGW  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  mcmd_e           push_cmd,
  input  logic [TAGW-1:0] push_tag,
  input  logic            promote,
  input  logic            pop,
  output mcmd_e           head_cmd,
  output logic [TAGW-1:0] head_tag,
  output logic [CW-1:0]   count,
  output logic            full
);
  mcmd_e           cmd_q [DEPTH];
  logic [TAGW-1:0] tag_q [DEPTH];
  logic [CW-1:0]   cnt_q;

  mcmd_e           c1 [DEPTH];
  logic [TAGW-1:0] t1 [DEPTH];
  mcmd_e           c2 [DEPTH];
  logic [TAGW-1:0] t2 [DEPTH];
  logic [CW-1:0]   n1, n2, lead, pos;
  logic            found;

  always_comb begin
    // stage 1: drop the head if a pop is taken
    c1 = cmd_q;
    t1 = tag_q;
    n1 = cnt_q;
    if (pop && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        c1[i] = cmd_q[i+1];
        t1[i] = tag_q[i+1];
      end
      c1[DEPTH-1] = CMD_RD;
      t1[DEPTH-1] = '0;
      n1 = cnt_q - 1'b1;
    end
    // length of the leading run of reads
    lead  = n1;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && CW'(i) < n1 && c1[i] != CMD_RD) begin
        lead  = CW'(i);
        found = 1'b1;
      end
    end
    pos = promote ? lead : n1;
    // stage 2: open a hole at pos and drop the new target in
    c2 = c1;
    t2 = t1;
    n2 = n1;
    if (push && n1 < CW'(DEPTH)) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (CW'(i) > pos) begin
          c2[i] = c1[i-1];
          t2[i] = t1[i-1];
        end
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == pos) begin
          c2[i] = push_cmd;
          t2[i] = push_tag;
        end
      end
      n2 = n1 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cmd_q[i] <= CMD_RD;
        tag_q[i] <= '0;
      end
    end else begin
      cnt_q <= n2;
      cmd_q <= c2;
      tag_q <= t2;
    end
  end

  assign head_cmd = cmd_q[0];
  assign head_tag = tag_q[0];
  assign count    = cnt_q;
  assign full     = (cnt_q == CW'(DEPTH));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(count));
  p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count != '0) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/mshr_state.sv
module mshr_state
  import mshr_pkg::*;
#(
  parameter int ADDRW = 32,
  parameter int ASIDW = 8,
  parameter int SZW   = 8,
  parameter int THW   = 4,
  parameter int TSW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [ADDRW-1:0] alloc_addr,
  input  logic [ASIDW-1:0] alloc_asid,
  input  mcmd_e            alloc_cmd,
  input  logic [SZW-1:0]   alloc_size,
  input  logic             take_thread,
  input  logic [THW-1:0]   new_thread,
  input  logic [TSW-1:0]   now,
  input  logic             upgrade,
  input  logic             mark,
  input  logic             dealloc,
  output mcmd_e            cmd,
  output logic [ADDRW-1:0] addr,
  output logic [ASIDW-1:0] asid,
  output logic [SZW-1:0]   size,
  output logic [TSW-1:0]   stamp,
  output logic [THW-1:0]   thread,
  output logic             busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= CMD_RD;
      addr   <= '0;
      asid   <= '0;
      size   <= '0;
      stamp  <= '0;
      thread <= '1;
      busy   <= 1'b0;
    end else begin
      if (alloc) begin
        addr  <= alloc_addr;
        asid  <= alloc_asid;
        size  <= alloc_size;
        stamp <= now;
        cmd   <= upgrade ? CMD_WR : alloc_cmd;
      end else if (upgrade) begin
        cmd <= CMD_WR;
      end
      if (alloc && take_thread) thread <= new_thread;
      if (dealloc)   busy <= 1'b0;
      else if (mark) busy <= 1'b1;
    end
  end

  p_upgrade_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upgrade |=> cmd == CMD_WR);
  p_dealloc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dealloc |=> !busy);
  p_mark_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !dealloc) |=> busy);
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAGW  = 8,
  parameter int ADDRW = 32,
  parameter int ASIDW = 8,
  parameter int SZW   = 8,
  parameter int THW   = 4,
  parameter int TSW   = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [ADDRW-1:0] alloc_addr,
  input  logic [ASIDW-1:0] alloc_asid,
  input  logic [1:0]       alloc_cmd,
  input  logic [SZW-1:0]   alloc_size,
  input  logic             alloc_has_tgt,
  input  logic [1:0]       alloc_tgt_cmd,
  input  logic [TAGW-1:0]  alloc_tgt_tag,
  input  logic [THW-1:0]   alloc_tgt_thread,
  input  logic             app_valid,
  output logic             app_ready,
  input  logic [1:0]       app_cmd,
  input  logic [TAGW-1:0]  app_tag,
  input  logic             mark_issue,
  input  logic             dealloc_valid,
  output logic             head_valid,
  input  logic             head_ready,
  output logic [1:0]       head_cmd,
  output logic [TAGW-1:0]  head_tag,
  output logic [1:0]       miss_cmd,
  output logic [ADDRW-1:0] miss_addr,
  output logic [ASIDW-1:0] miss_asid,
  output logic [SZW-1:0]   miss_size,
  output logic [TSW-1:0]   miss_time,
  output logic [THW-1:0]   miss_thread,
  output logic             in_service,
  output logic [CW-1:0]    tgt_count,
  output logic             tgt_full
);
  logic            alloc_fire, dealloc_fire, app_fire, pop_fire;
  logic            push, promote, upgrade;
  mcmd_e           push_cmd, cur_cmd, q_head_cmd;
  logic [TAGW-1:0] push_tag;
  logic [TSW-1:0]  now;

  assign alloc_fire   = alloc_valid && (tgt_count == '0);
  assign dealloc_fire = dealloc_valid && !alloc_valid && (tgt_count == '0);
  assign app_ready    = !tgt_full && !alloc_valid && !dealloc_valid;
  assign app_fire     = app_valid && app_ready;
  assign head_valid   = (tgt_count != '0);
  assign pop_fire     = head_valid && head_ready;

  assign push     = app_fire || (alloc_fire && alloc_has_tgt);
  assign push_cmd = alloc_fire ? mcmd_e'(alloc_tgt_cmd) : mcmd_e'(app_cmd);
  assign push_tag = alloc_fire ? alloc_tgt_tag : app_tag;
  assign promote  = app_fire && in_service && (cur_cmd == CMD_RD)
                    && (push_cmd == CMD_INV);
  assign upgrade  = push && !in_service && (push_cmd == CMD_WR);

  mshr_tick #(.TSW(TSW)) u_tick (.clk(clk), .rst_n(rst_n), .now(now));

  mshr_tq #(.DEPTH(DEPTH), .TAGW(TAGW)) u_tq (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_cmd(push_cmd), .push_tag(push_tag),
    .promote(promote), .pop(pop_fire),
    .head_cmd(q_head_cmd), .head_tag(head_tag),
    .count(tgt_count), .full(tgt_full)
  );

  mshr_state #(.ADDRW(ADDRW), .ASIDW(ASIDW), .SZW(SZW), .THW(THW), .TSW(TSW)) u_st (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc_fire), .alloc_addr(alloc_addr), .alloc_asid(alloc_asid),
    .alloc_cmd(mcmd_e'(alloc_cmd)), .alloc_size(alloc_size),
    .take_thread(alloc_has_tgt), .new_thread(alloc_tgt_thread),
    .now(now), .upgrade(upgrade), .mark(mark_issue), .dealloc(dealloc_fire),
    .cmd(cur_cmd), .addr(miss_addr), .asid(miss_asid), .size(miss_size),
    .stamp(miss_time), .thread(miss_thread), .busy(in_service)
  );

  assign head_cmd = q_head_cmd;
  assign miss_cmd = cur_cmd;

  p_alloc_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> tgt_count == '0);
  p_dealloc_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dealloc_valid |-> tgt_count == '0);
  p_app_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (app_fire && !pop_fire) |=> tgt_count == $past(tgt_count) + 1'b1);
  p_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_full |-> !app_ready);
endmodule

// File: tb/mshr_entry_tb.sv
module mshr_entry_tb;
  localparam int DEPTH = 4, TAGW = 4, ADDRW = 16, ASIDW = 4, SZW = 4, THW = 4, TSW = 16;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] OP_ALLOC = 3'd0, OP_ALLOCN = 3'd1, OP_APP = 3'd2,
                         OP_POP = 3'd3, OP_MARK = 3'd4, OP_DEAL = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] acmd;
    logic [1:0] tcmd;
    logic [3:0] tag;
    logic [3:0] cnt;
    logic [1:0] hc;
    logic [3:0] ht;
    logic [1:0] oc;
    logic       isv;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{OP_ALLOC, 2'd0, 2'd0, 4'd1, 4'd1, 2'd0, 4'd1, 2'd0, 1'b0},  // R2 R3
    '{OP_APP,   2'd0, 2'd0, 4'd2, 4'd2, 2'd0, 4'd1, 2'd0, 1'b0},  // R4
    '{OP_MARK,  2'd0, 2'd0, 4'd0, 4'd2, 2'd0, 4'd1, 2'd0, 1'b1},  // R10
    '{OP_APP,   2'd0, 2'd1, 4'd3, 4'd3, 2'd0, 4'd1, 2'd0, 1'b1},  // R6 no upgrade
    '{OP_APP,   2'd0, 2'd2, 4'd4, 4'd4, 2'd0, 4'd1, 2'd0, 1'b1},  // R5 promote
    '{OP_APP,   2'd0, 2'd0, 4'd5, 4'd4, 2'd0, 4'd1, 2'd0, 1'b1},  // R7 refused
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd3, 2'd0, 4'd2, 2'd0, 1'b1},  // R8
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd2, 2'd2, 4'd4, 2'd0, 1'b1},  // R5 order
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd1, 2'd1, 4'd3, 2'd0, 1'b1},
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd0, 1'b1},
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd0, 1'b1},  // R8 empty
    '{OP_DEAL,  2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd0, 1'b0},  // R9
    '{OP_ALLOCN,2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd0, 1'b0},
    '{OP_APP,   2'd0, 2'd1, 4'd6, 4'd1, 2'd1, 4'd6, 2'd1, 1'b0},  // R6 upgrade
    '{OP_APP,   2'd0, 2'd2, 4'd7, 4'd2, 2'd1, 4'd6, 2'd1, 1'b0},  // R4 tail
    '{OP_MARK,  2'd0, 2'd0, 4'd0, 4'd2, 2'd1, 4'd6, 2'd1, 1'b1},
    '{OP_APP,   2'd0, 2'd2, 4'd8, 4'd3, 2'd1, 4'd6, 2'd1, 1'b1},  // R5 cmd is write
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd2, 2'd2, 4'd7, 2'd1, 1'b1},
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd1, 2'd2, 4'd8, 2'd1, 1'b1},
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd1, 1'b1},
    '{OP_DEAL,  2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd1, 1'b0},
    '{OP_ALLOC, 2'd0, 2'd0, 4'd9, 4'd1, 2'd0, 4'd9, 2'd0, 1'b0},
    '{OP_MARK,  2'd0, 2'd0, 4'd0, 4'd1, 2'd0, 4'd9, 2'd0, 1'b1},
    '{OP_APP,   2'd0, 2'd2, 4'd10,4'd2, 2'd0, 4'd9, 2'd0, 1'b1},  // R5 all reads
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd1, 2'd2, 4'd10,2'd0, 1'b1},
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd0, 1'b1},
    '{OP_DEAL,  2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd0, 1'b0},
    '{OP_ALLOC, 2'd0, 2'd1, 4'd11,4'd1, 2'd1, 4'd11,2'd1, 1'b0},  // R6 via alloc
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd1, 1'b0},
    '{OP_DEAL,  2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd1, 1'b0},
    '{OP_ALLOC, 2'd1, 2'd0, 4'd12,4'd1, 2'd0, 4'd12,2'd1, 1'b0},  // R2 cmd kept
    '{OP_POP,   2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd1, 1'b0},
    '{OP_DEAL,  2'd0, 2'd0, 4'd0, 4'd0, 2'd0, 4'd0, 2'd1, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             alloc_valid = 1'b0, alloc_has_tgt = 1'b0;
  logic [ADDRW-1:0] alloc_addr = '0;
  logic [ASIDW-1:0] alloc_asid = '0;
  logic [1:0]       alloc_cmd = '0, alloc_tgt_cmd = '0, app_cmd = '0;
  logic [SZW-1:0]   alloc_size = '0;
  logic [TAGW-1:0]  alloc_tgt_tag = '0, app_tag = '0;
  logic [THW-1:0]   alloc_tgt_thread = '0;
  logic             app_valid = 1'b0, mark_issue = 1'b0, dealloc_valid = 1'b0, head_ready = 1'b0;
  logic             app_ready, head_valid, in_service, tgt_full;
  logic [1:0]       head_cmd, miss_cmd;
  logic [TAGW-1:0]  head_tag;
  logic [ADDRW-1:0] miss_addr;
  logic [ASIDW-1:0] miss_asid;
  logic [SZW-1:0]   miss_size;
  logic [TSW-1:0]   miss_time;
  logic [THW-1:0]   miss_thread;
  logic [CW-1:0]    tgt_count;

  int total = 0;
  int bad = 0;
  logic [TSW-1:0] t0;

  always #2.5 clk = ~clk;

  mshr_entry #(.DEPTH(DEPTH), .TAGW(TAGW), .ADDRW(ADDRW), .ASIDW(ASIDW),
               .SZW(SZW), .THW(THW), .TSW(TSW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] acmd,
                       input logic [1:0] tcmd, input logic [3:0] tag);
    alloc_valid   = (op == OP_ALLOC) || (op == OP_ALLOCN);
    alloc_has_tgt = (op == OP_ALLOC);
    alloc_cmd     = acmd;
    alloc_tgt_cmd = tcmd;
    alloc_tgt_tag = tag;
    alloc_tgt_thread = tag;
    app_valid     = (op == OP_APP);
    app_cmd       = tcmd;
    app_tag       = tag;
    head_ready    = (op == OP_POP);
    mark_issue    = (op == OP_MARK);
    dealloc_valid = (op == OP_DEAL);
  endtask

  task automatic idle();
    drive(3'd7, 2'd0, 2'd0, 4'd0);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 in_service", in_service, 0);
    chk("R1 count", tgt_count, 0);
    chk("R1 thread", miss_thread, 4'hF);
    chk("R1 head_valid", head_valid, 0);
    chk("R1 app_ready", app_ready, 1);

    // table walk: R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].op, VEC[k].acmd, VEC[k].tcmd, VEC[k].tag);
      if (VEC[k].op == OP_APP && VEC[k].cnt == 4'(DEPTH) && k == 5)
        chk("R7 ready low when full", app_ready, 0);
      cyc();
      chk($sformatf("R11 count vec%0d", k), tgt_count, VEC[k].cnt);
      chk($sformatf("R11 head_valid vec%0d", k), head_valid, VEC[k].cnt != 0);
      if (VEC[k].cnt != 0) begin
        chk($sformatf("R5 head cmd vec%0d", k), head_cmd, VEC[k].hc);
        chk($sformatf("R8 head tag vec%0d", k), head_tag, VEC[k].ht);
      end
      chk($sformatf("R6 miss_cmd vec%0d", k), miss_cmd, VEC[k].oc);
      chk($sformatf("R10 in_service vec%0d", k), in_service, VEC[k].isv);
    end
    chk("R3 thread from first target", miss_thread, 4'd12);

    // R2 recorded fields and timestamp spacing
    alloc_valid = 1'b1; alloc_addr = 16'hBEEF; alloc_asid = 4'h6;
    alloc_size = 4'h9; alloc_cmd = 2'd2; alloc_has_tgt = 1'b1;
    alloc_tgt_cmd = 2'd0; alloc_tgt_tag = 4'h3; alloc_tgt_thread = 4'h5;
    cyc();
    chk("R2 addr", miss_addr, 16'hBEEF);
    chk("R2 asid", miss_asid, 4'h6);
    chk("R2 size", miss_size, 4'h9);
    chk("R2 cmd", miss_cmd, 2'd2);
    chk("R3 thread", miss_thread, 4'h5);
    t0 = miss_time;
    head_ready = 1'b1; cyc();
    dealloc_valid = 1'b1; cyc();
    cyc(); cyc(); cyc();
    alloc_valid = 1'b1; alloc_has_tgt = 1'b0; alloc_cmd = 2'd0; cyc();
    chk("R2 timestamp delta", miss_time - t0, 6);

    // R8 pop and append same cycle: queue [R1,R2], in service read
    app_valid = 1'b1; app_cmd = 2'd0; app_tag = 4'd1; cyc();
    app_valid = 1'b1; app_cmd = 2'd0; app_tag = 4'd2; cyc();
    mark_issue = 1'b1; cyc();
    head_ready = 1'b1; app_valid = 1'b1; app_cmd = 2'd2; app_tag = 4'd7; cyc();
    chk("R8 overlap count", tgt_count, 2);
    chk("R8 overlap head", head_tag, 4'd2);
    head_ready = 1'b1; cyc();
    chk("R5 overlap promoted", head_tag, 4'd7);
    chk("R5 overlap cmd", head_cmd, 2'd2);

    // R7 fill to full, check flag
    app_valid = 1'b1; app_cmd = 2'd1; app_tag = 4'd3; cyc();
    app_valid = 1'b1; app_tag = 4'd4; cyc();
    app_valid = 1'b1; app_tag = 4'd5; cyc();
    chk("R7 full flag", tgt_full, 1);
    chk("R7 ready low", app_ready, 0);
    chk("R7 count", tgt_count, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule